// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block holds the global power mode of a small microcontroller-style system and sequences its moves between four modes: full run, a reduced run mode, sleep and hibernate. Firmware picks a mode or updates a per-subsystem clock-enable template through a narrow register write port. In the two run modes each subsystem clock follows its template bit. In sleep and hibernate every subsystem clock is gated, whatever the template holds.

Wakeup inputs are filtered by the current mode. An accepted wakeup always lands in full run mode and sets the CPU template bit again, so a CPU that switched itself off comes back. Leaving sleep or hibernate takes a programmable number of cycles. The status output keeps showing the low-power mode until that count has run out.

A single main regulator enable models the digital and analog supplies together. It is held on in the run modes and while waking. In sleep it is pulsed on and off periodically. In hibernate it is held off.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, mode_stat reads 0 (full run), clk_en is all ones and main_reg_en is 1.
- R2: A write with wr_sel=0 sets the mode from wr_data[1:0] on the next rising edge: 0 full run, 1 reduced run, 2 sleep, 3 hibernate. mode_stat reports the new mode from that edge on.
- R3: A write with wr_sel=1 loads the template from wr_data. In modes 0 and 1, clk_en equals the template. Bit 0 of the template is the CPU enable.
- R4: In sleep and hibernate, clk_en is all zeros. Writes to either register are ignored until the status reads full run again.
- R5: In sleep, wake_src bits 0 (port interrupt), 1 (real-time clock), 2 (timewheel) and 3 (low-voltage detect) start a wakeup. Bit 4 (any other interrupt) has no effect.
- R6: In hibernate, only wake_src bit 0 starts a wakeup.
- R7: Take the rising edge that samples an accepted wakeup out of sleep as edge zero. mode_stat keeps the sleep code until rising edge SLEEP_WAKE_CYC after it, and reads 0 from that edge on. Hibernate behaves the same way with HIB_WAKE_CYC.
- R8: In reduced run mode, any nonzero wake_src returns the mode to full run on the next edge.
- R9: Every accepted wakeup sets template bit 0 to 1, whatever was written before. This includes a wakeup seen in full run mode.
- R10: A wakeup accepted in the same cycle as a mode write wins, so the mode becomes full run.
- R11: main_reg_en is 1 in modes 0 and 1 and while waking, and 0 in hibernate. In sleep it is 1 on the first BUZZ_ON of every BUZZ_PERIOD cycles, counting from the first sleep cycle.
- R12: rst_n low acts at once, with no clock edge, and reloads the template with all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the mode register, 1 selects the template |
| wr_data | input | NUM_SUBSYS | Write data (mode code in bits 1:0) |
| wake_src | input | 5 | Wakeup sources: port, clock, timewheel, low voltage, other irq |
| clk_en | output | NUM_SUBSYS | Per-subsystem clock enables, bit 0 is the CPU |
| mode_stat | output | 2 | Current reported mode |
| main_reg_en | output | 1 | Main digital/analog regulator enable |

## Verification
The bench builds the block with six subsystems, a sleep wake count of 3, a hibernate wake count of 7, and a regulator pulse of 1 cycle in every 4. The unequal wake counts let a single run tell the two latencies apart cycle by cycle. The short pulse period lets two full regulator periods be checked early in a sleep stay. With six template bits, random templates differ from the all-ones reset value in ways that show up on the clock-enable outputs.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_ALT   = 2'd1,
    MODE_SLEEP = 2'd2,
    MODE_HIB   = 2'd3
  } pwr_mode_e;

  typedef struct packed {
    logic tmplLoad;
    logic cpuSet;
    logic gateAll;
  } dp_strobe_t;

  localparam int WAKE_W = 5;
endpackage

// File: rtl/pms_ctrl.sv
module pms_ctrl
  import pms_pkg::*;
#(
  parameter int SLEEP_WAKE_CYC = 4,
  parameter int HIB_WAKE_CYC   = 12,
  parameter int BUZZ_PERIOD    = 8,
  parameter int BUZZ_ON        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [1:0]        wrMode,
  input  logic [WAKE_W-1:0] wakeSrc,
  output dp_strobe_t        strobe,
  output logic [1:0]        modeStat,
  output logic              mainRegEn
);
  localparam int MAX_WAKE = (HIB_WAKE_CYC > SLEEP_WAKE_CYC) ? HIB_WAKE_CYC : SLEEP_WAKE_CYC;
  localparam int CNT_W    = $clog2(MAX_WAKE + 1);
  localparam int BUZZ_W   = $clog2(BUZZ_PERIOD);

  pwr_mode_e         mode;
  logic              waking;
  logic [CNT_W-1:0]  wakeCnt;
  logic [BUZZ_W-1:0] buzzCnt;
  logic [WAKE_W-1:0] wakeMask;
  logic              lowPwr;
  logic              wakeHit;

  always_comb begin
    case (mode)
      MODE_SLEEP: wakeMask = 5'b01111;
      MODE_HIB:   wakeMask = 5'b00001;
      default:    wakeMask = 5'b11111;
    endcase
    lowPwr  = (mode == MODE_SLEEP) || (mode == MODE_HIB);
    wakeHit = (|(wakeSrc & wakeMask)) && !waking;
    strobe.tmplLoad = wrEn && wrSel && !lowPwr;
    strobe.cpuSet   = wakeHit;
    strobe.gateAll  = lowPwr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_RUN;
      waking  <= 1'b0;
      wakeCnt <= '0;
    end else if (waking) begin
      if (wakeCnt == '0) begin
        mode   <= MODE_RUN;
        waking <= 1'b0;
      end else begin
        wakeCnt <= wakeCnt - 1'b1;
      end
    end else if (wakeHit) begin
      if (lowPwr) begin
        waking  <= 1'b1;
        wakeCnt <= (mode == MODE_HIB) ? CNT_W'(HIB_WAKE_CYC - 1) : CNT_W'(SLEEP_WAKE_CYC - 1);
      end else begin
        mode <= MODE_RUN;
      end
    end else if (wrEn && !wrSel && !lowPwr) begin
      mode <= pwr_mode_e'(wrMode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buzzCnt <= '0;
    end else if (mode == MODE_SLEEP && !waking) begin
      buzzCnt <= (buzzCnt == BUZZ_W'(BUZZ_PERIOD - 1)) ? '0 : buzzCnt + 1'b1;
    end else begin
      buzzCnt <= '0;
    end
  end

  always_comb begin
    if (waking || !lowPwr)        mainRegEn = 1'b1;
    else if (mode == MODE_SLEEP)  mainRegEn = ({1'b0, buzzCnt} < (BUZZ_W + 1)'(BUZZ_ON));
    else                          mainRegEn = 1'b0;
  end

  assign modeStat = mode;

  assert_sleep_ignores_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SLEEP && !waking && wakeSrc == 5'b10000 && !wrEn) |=> (mode == MODE_SLEEP && !waking));

  assert_hib_port_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HIB && !waking && !wakeSrc[0]) |=> (mode == MODE_HIB && !waking));

  assert_wake_beats_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!lowPwr && (|wakeSrc) && wrEn && !wrSel) |=> (mode == MODE_RUN));

  assert_hib_reg_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HIB && !waking) |-> !mainRegEn);
endmodule

// File: rtl/pms_datapath.sv
module pms_datapath
  import pms_pkg::*;
#(
  parameter int NUM_SUBSYS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dp_strobe_t            strobe,
  input  logic [NUM_SUBSYS-1:0] wrData,
  output logic [NUM_SUBSYS-1:0] clkEn
);
  logic [NUM_SUBSYS-1:0] tmpl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmpl <= '1;
    end else begin
      if (strobe.tmplLoad) tmpl[NUM_SUBSYS-1:1] <= wrData[NUM_SUBSYS-1:1];
      if (strobe.cpuSet)        tmpl[0] <= 1'b1;
      else if (strobe.tmplLoad) tmpl[0] <= wrData[0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SUBSYS; g++) begin : g_gate
      assign clkEn[g] = tmpl[g] && !strobe.gateAll;
    end
  endgenerate

  assert_cpu_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.cpuSet |=> tmpl[0]);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int NUM_SUBSYS     = 8,
  parameter int SLEEP_WAKE_CYC = 4,
  parameter int HIB_WAKE_CYC   = 12,
  parameter int BUZZ_PERIOD    = 8,
  parameter int BUZZ_ON        = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_sel,
  input  logic [NUM_SUBSYS-1:0] wr_data,
  input  logic [4:0]            wake_src,
  output logic [NUM_SUBSYS-1:0] clk_en,
  output logic [1:0]            mode_stat,
  output logic                  main_reg_en
);
  dp_strobe_t strobe;

  pms_ctrl #(
    .SLEEP_WAKE_CYC(SLEEP_WAKE_CYC),
    .HIB_WAKE_CYC  (HIB_WAKE_CYC),
    .BUZZ_PERIOD   (BUZZ_PERIOD),
    .BUZZ_ON       (BUZZ_ON)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wr_en),
    .wrSel    (wr_sel),
    .wrMode   (wr_data[1:0]),
    .wakeSrc  (wake_src),
    .strobe   (strobe),
    .modeStat (mode_stat),
    .mainRegEn(main_reg_en)
  );

  pms_datapath #(.NUM_SUBSYS(NUM_SUBSYS)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe),
    .wrData(wr_data),
    .clkEn (clk_en)
  );

  assert_lowpwr_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat[1]) |-> (clk_en == '0));
endmodule

// File: tb/pwr_mode_seq_bench.sv
`timescale 1ns/1ps
module pwr_mode_seq_bench;
  localparam int NS = 6;
  localparam int SW = 3;
  localparam int HW = 7;
  localparam int BP = 4;
  localparam int BO = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [NS-1:0] wr_data = '0;
  logic [4:0] wake_src = '0;
  logic [NS-1:0] clk_en;
  logic [1:0] mode_stat;
  logic main_reg_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int expMode;
  logic [NS-1:0] expTmpl;

  always #2.5 clk = ~clk;

  pwr_mode_seq #(.NUM_SUBSYS(NS), .SLEEP_WAKE_CYC(SW), .HIB_WAKE_CYC(HW),
                 .BUZZ_PERIOD(BP), .BUZZ_ON(BO)) u_pwr_mode_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wake_src(wake_src), .clk_en(clk_en), .mode_stat(mode_stat), .main_reg_en(main_reg_en));

  function automatic logic [NS-1:0] expClk(int m, logic [NS-1:0] t);
    return (m >= 2) ? '0 : t;
  endfunction

  function automatic logic expBuzz(int i);
    return (i % BP) < BO;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic writeReg(logic sel, logic [NS-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulseWake(logic [4:0] s);
    wake_src = s;
    tick();
    wake_src = '0;
  endtask

  task automatic checkRun(string req);
    check({req, " mode"}, mode_stat, expMode);
    check({req, " clk_en"}, clk_en, expClk(expMode, expTmpl));
    check({req, " reg"}, main_reg_en, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    tick(); tick();
    rst_n = 1'b1;
    tick();
    expMode = 0; expTmpl = '1;
    // R1 reset state
    check("R1 mode", mode_stat, 0);
    check("R1 clk_en", clk_en, 6'h3F);
    check("R1 reg", main_reg_en, 1);

    // R2/R3 directed writes
    writeReg(1'b1, 6'h2A); expTmpl = 6'h2A;
    checkRun("R3 template");
    writeReg(1'b0, 6'd1); expMode = 1;
    checkRun("R2 alt");
    // R8 any source exits reduced run
    pulseWake(5'b10000); expMode = 0; expTmpl[0] = 1'b1;
    checkRun("R8 irq wake");

    // R9 wake in full run resets CPU bit
    writeReg(1'b1, 6'h14); expTmpl = 6'h14;
    check("R9 cpu off", clk_en, 6'h14);
    pulseWake(5'b00100); expTmpl = 6'h15;
    check("R9 cpu back", clk_en, 6'h15);

    // Random run-mode traffic
    for (int it = 0; it < 300; it++) begin
      int op = $urandom % 4;
      logic [NS-1:0] d = NS'($urandom);
      logic [4:0] w = 5'($urandom % 31 + 1);
      case (op)
        0: begin writeReg(1'b1, d); expTmpl = d; checkRun("R3 rand tmpl"); end
        1: begin writeReg(1'b0, NS'($urandom % 2)); expMode = wr_data[0]; checkRun("R2 rand mode"); end
        2: begin pulseWake(w); expMode = 0; expTmpl[0] = 1'b1; checkRun("R8 R9 rand wake"); end
        default: begin
          wr_en = 1'b1; wr_sel = 1'b0; wr_data = NS'(2 + $urandom % 2); wake_src = w;
          tick();
          wr_en = 1'b0; wake_src = '0;
          expMode = 0; expTmpl[0] = 1'b1;
          checkRun("R10 wake beats write");
        end
      endcase
    end

    // Sleep: gating, regulator pulse, ignored writes, filters, latency
    writeReg(1'b1, 6'h2C); expTmpl = 6'h2C;
    writeReg(1'b0, 6'd2);
    for (int i = 0; i < 2 * BP; i++) begin
      check("R4 sleep gated", clk_en, 0);
      check("R11 sleep pulse", main_reg_en, expBuzz(i));
      tick();
    end
    writeReg(1'b1, 6'h00);
    writeReg(1'b0, 6'd3);
    check("R4 mode write ignored", mode_stat, 2);
    pulseWake(5'b10000);
    check("R5 irq ignored", mode_stat, 2);
    pulseWake(5'b00010);
    for (int n = 1; n <= SW; n++) begin
      check("R11 reg on waking", main_reg_en, 1);
      tick();
      check("R7 sleep latency", mode_stat, (n < SW) ? 2 : 0);
    end
    check("R4 R9 template kept, cpu on", clk_en, 6'h2D);

    // Hibernate
    writeReg(1'b1, 6'h30); expTmpl = 6'h30;
    writeReg(1'b0, 6'd3);
    check("R11 hib reg off", main_reg_en, 0);
    check("R4 hib gated", clk_en, 0);
    for (int b = 1; b < 5; b++) begin
      pulseWake(5'(1 << b));
      check("R6 hib filter", mode_stat, 3);
    end
    pulseWake(5'b00001);
    for (int n = 1; n <= HW; n++) begin
      tick();
      check("R7 hib latency", mode_stat, (n < HW) ? 3 : 0);
    end
    check("R9 hib cpu on", clk_en, 6'h31);

    // R12 asynchronous reset mid-cycle
    writeReg(1'b1, 6'h00);
    #1 rst_n = 1'b0;
    #0.5 check("R12 async template", clk_en, 6'h3F);
    check("R12 async mode", mode_stat, 0);
    tick();
    rst_n = 1'b1;
    tick();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule